// File: doc/BRIEF.md
# Bus idle pacing and wake controller

This block decides when the next SPI transaction toward a sleepy peripheral may begin. The peripheral needs a quiet interval after each transaction ends. It also drops into a low-power state when the bus has been quiet for a long time. A millisecond tick drives all timing. The controller keeps two elapsed-time counters: one runs from the most recent end of a transaction, the other from the most recent start grant. A start request first waits out the quiet interval. It then runs a wake sequence if the sleep limit has passed. Only then does it issue a one-cycle start grant.

The quiet interval can be cut short by a ready interrupt from the peripheral. At reset nobody knows whether that interrupt line is wired and working, so the block learns it at run time. At each start request it checks whether an interrupt has ever been seen. A seen interrupt switches pacing for good to a long interrupt-bounded timeout. A few requests with no interrupt freeze pacing in the short fixed-delay mode. The wake sequence drives chip-select on its own, with no clocking, for a hold time. It then releases chip-select and lets the peripheral settle before the grant. Moving the payload itself is left to the SPI engine that consumes the grant.

Top module: `pace_wake_ctrl`

## Requirements
- R1: In fixed-delay mode, the start grant comes in the cycle after the one in which 3 ms ticks have been counted since the latest `xfer_done`. Ticks are counted on the clock edges after the `xfer_done` edge, and a tick on that same edge does not count. This guarantees a gap of at least 2 ms.
- R2: A `ready_irq` pulse during the gap wait ends the wait at once: the grant (or the wake sequence) begins in the next cycle. A pulse that came after the previous grant but before the request counts as well.
- R3: If `ready_irq` has been seen at any time before a request's gap check, and confirmation is still open, pacing switches permanently to interrupt mode. In interrupt mode the gap limit is 750 ticks.
- R4: Each request whose gap check finds no interrupt seen counts as one confirmation attempt. After 3 such attempts confirmation closes. Fixed-delay pacing then stays in force, even if interrupts arrive later.
- R5: A wake sequence runs before the grant when 1000 or more ticks have been counted since the last grant, or when there has been no grant since reset.
- R6: The wake sequence holds `wake_cs` high until 2 ticks have been counted. It then keeps `wake_cs` low until 2 further ticks have been counted, and the grant follows in the next cycle. `wake_cs` and `start_grant` are never high together.
- R7: Every grant re-arms the sleep deadline, including grants that had no wake sequence before them.
- R8: Each `xfer_done` pulse restarts the gap measurement, whatever the outcome of the transaction. A second end replaces the first.
- R9: The elapsed-time counters saturate rather than wrap. After an arbitrarily long idle, the gap counts as met (even the 750-tick limit) and a wake is required.
- R10: The gap check finishes before the wake check starts, so `wake_cs` never rises before the gap is met. `start_grant` is high for exactly one cycle. Requests that arrive while a request is in progress are ignored.
- R11: During and right after reset, `start_grant` and `wake_cs` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per elapsed millisecond |
| xfer_done | input | 1 | One-cycle pulse when a transaction ends, with or without error |
| start_req | input | 1 | Request to start the next transaction |
| ready_irq | input | 1 | One-cycle ready interrupt from the peripheral |
| start_grant | output | 1 | One-cycle permission to begin the transaction |
| wake_cs | output | 1 | Drive chip-select alone, without clocking, for the wake pulse |

## Verification
The bench targets the tick-exact gap boundary. A grant that comes one tick early or late shows up as a changed tick count between the end of the transaction and the grant. It also drives the confirmation attempt that closes on its third miss: a design that counts one attempt too many switches to the 750-tick gap and stalls a later fixed-delay request. The bench checks a grant just under the sleep limit that follows an earlier wake. A design that re-arms the deadline only on wakes would wrongly wake there. It also runs an idle longer than the counter range: a wrapping counter would report a short gap, stall in interrupt mode and skip the wake.

// File: rtl/pace_pkg.sv
package pace_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_GAP     = 3'd1,
        PH_WAKE_CS = 3'd2,
        PH_SETTLE  = 3'd3,
        PH_GRANT   = 3'd4
    } pace_phase_e;

    // Conditions the sequencer consumes, formed from the elapsed-time counters.
    typedef struct packed {
        logic gap_met;
        logic asleep;
    } pace_cond_t;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pace_elapsed.sv
// Saturating tick counter, cleared by an event; starts saturated at reset.
module pace_elapsed #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '1;
        end else if (clear) begin
            count <= '0;
        end else if (tick && (count != '1)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pace_confirm.sv
// Run-time detection of a working ready interrupt.
module pace_confirm #(
    parameter int TRIES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ready_irq,
    input  logic eval,
    output logic irq_mode
);
    generate
        if (TRIES == 0) begin : g_never
            logic unused_in;
            assign unused_in = ready_irq ^ eval ^ clk ^ rst;
            assign irq_mode  = 1'b0;
        end else begin : g_learn
            localparam int AW = $clog2(TRIES + 1);
            localparam logic [AW-1:0] LAST_TRY = AW'(TRIES - 1);

            logic          seen;
            logic          open_q;
            logic [AW-1:0] tries_q;
            logic          mode_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    seen    <= 1'b0;
                    open_q  <= 1'b1;
                    tries_q <= '0;
                    mode_q  <= 1'b0;
                end else begin
                    if (ready_irq) seen <= 1'b1;
                    if (eval && open_q) begin
                        if (seen) begin
                            mode_q <= 1'b1;
                            open_q <= 1'b0;
                        end else begin
                            tries_q <= tries_q + 1'b1;
                            if (tries_q == LAST_TRY) open_q <= 1'b0;
                        end
                    end
                end
            end
            assign irq_mode = mode_q;
        end
    endgenerate
endmodule

// File: rtl/pace_seq.sv
// Request sequencer: gap wait, optional wake pulse and settle, one-cycle grant.
module pace_seq
    import pace_pkg::*;
#(
    parameter int CS_HOLD = 2,
    parameter int SETTLE  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       start_req,
    input  pace_cond_t cond,
    output logic       eval_pulse,
    output logic       start_grant,
    output logic       wake_cs
);
    localparam int TW = $clog2(max2(CS_HOLD, SETTLE) + 1);
    localparam logic [TW-1:0] HOLD_LIM   = TW'(CS_HOLD);
    localparam logic [TW-1:0] SETTLE_LIM = TW'(SETTLE);

    pace_phase_e ph, ph_n;
    logic [TW-1:0] tcnt, tcnt_n, tcnt_inc;

    assign tcnt_inc = tcnt + TW'(tick);

    always_comb begin
        ph_n   = ph;
        tcnt_n = '0;
        case (ph)
            PH_IDLE:  if (start_req) ph_n = PH_GAP;
            PH_GAP:   if (cond.gap_met) ph_n = cond.asleep ? PH_WAKE_CS : PH_GRANT;
            PH_WAKE_CS: begin
                if (tcnt_inc >= HOLD_LIM) ph_n = PH_SETTLE;
                else tcnt_n = tcnt_inc;
            end
            PH_SETTLE: begin
                if (tcnt_inc >= SETTLE_LIM) ph_n = PH_GRANT;
                else tcnt_n = tcnt_inc;
            end
            PH_GRANT: ph_n = PH_IDLE;
            default:  ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            tcnt <= '0;
        end else begin
            ph   <= ph_n;
            tcnt <= tcnt_n;
        end
    end

    assign eval_pulse  = (ph == PH_GAP) && cond.gap_met;
    assign start_grant = (ph == PH_GRANT);
    assign wake_cs     = (ph == PH_WAKE_CS);
endmodule

// File: rtl/pace_wake_ctrl.sv
module pace_wake_ctrl
    import pace_pkg::*;
#(
    parameter int GAP_TICKS     = 3,
    parameter int IRQ_GAP_TICKS = 750,
    parameter int SLEEP_TICKS   = 1000,
    parameter int CS_HOLD_TICKS = 2,
    parameter int SETTLE_TICKS  = 2,
    parameter int CONFIRM_TRIES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ms_tick,
    input  logic xfer_done,
    input  logic start_req,
    input  logic ready_irq,
    output logic start_grant,
    output logic wake_cs
);
    localparam int LIM_MAX = max2(max2(GAP_TICKS, IRQ_GAP_TICKS), SLEEP_TICKS);
    // One spare bit so saturation sits well above every limit.
    localparam int CNT_W = $clog2(LIM_MAX + 1) + 1;
    localparam logic [CNT_W-1:0] FIX_LIM   = CNT_W'(GAP_TICKS);
    localparam logic [CNT_W-1:0] IRQ_LIM   = CNT_W'(IRQ_GAP_TICKS);
    localparam logic [CNT_W-1:0] SLEEP_LIM = CNT_W'(SLEEP_TICKS);

    logic [CNT_W-1:0] since_end, since_grant, gap_lim;
    logic             irq_mode, irq_pend, eval;
    pace_cond_t       cond;

    pace_elapsed #(.W(CNT_W)) u_since_end (
        .clk(clk), .rst(rst), .tick(ms_tick), .clear(xfer_done), .count(since_end)
    );

    pace_elapsed #(.W(CNT_W)) u_since_grant (
        .clk(clk), .rst(rst), .tick(ms_tick), .clear(start_grant), .count(since_grant)
    );

    pace_confirm #(.TRIES(CONFIRM_TRIES)) u_confirm (
        .clk(clk), .rst(rst), .ready_irq(ready_irq), .eval(eval), .irq_mode(irq_mode)
    );

    // Interrupt latched until the grant it released has been issued.
    always_ff @(posedge clk) begin
        if (rst)            irq_pend <= 1'b0;
        else if (ready_irq) irq_pend <= 1'b1;
        else if (start_grant) irq_pend <= 1'b0;
    end

    always_comb begin
        gap_lim      = irq_mode ? IRQ_LIM : FIX_LIM;
        cond.gap_met = (since_end >= gap_lim) || ready_irq || irq_pend;
        cond.asleep  = (since_grant >= SLEEP_LIM);
    end

    pace_seq #(.CS_HOLD(CS_HOLD_TICKS), .SETTLE(SETTLE_TICKS)) u_seq (
        .clk(clk), .rst(rst), .tick(ms_tick), .start_req(start_req), .cond(cond),
        .eval_pulse(eval), .start_grant(start_grant), .wake_cs(wake_cs)
    );
endmodule

// File: rtl/pace_wake_ctrl_chk.sv
module pace_wake_ctrl_chk #(
    parameter int GAP_TICKS     = 3,
    parameter int CS_HOLD_TICKS = 2,
    parameter int SETTLE_TICKS  = 2
) (
    input logic clk,
    input logic rst,
    input logic ms_tick,
    input logic xfer_done,
    input logic ready_irq,
    input logic start_grant,
    input logic wake_cs
);
    int   end_ticks, cs_ticks, settle_ticks;
    logic irq_since, woke;

    always_ff @(posedge clk) begin
        if (rst) begin
            end_ticks    <= 32'h3fff_ffff;
            cs_ticks     <= 0;
            settle_ticks <= 0;
            irq_since    <= 1'b0;
            woke         <= 1'b0;
        end else begin
            if (xfer_done) end_ticks <= 0;
            else if (ms_tick && end_ticks < 32'h3fff_ffff) end_ticks <= end_ticks + 1;
            cs_ticks <= wake_cs ? cs_ticks + int'(ms_tick) : 0;
            if (ready_irq) irq_since <= 1'b1;
            else if (start_grant) irq_since <= 1'b0;
            if (wake_cs) begin
                woke         <= 1'b1;
                settle_ticks <= 0;
            end else if (start_grant) begin
                woke         <= 1'b0;
                settle_ticks <= 0;
            end else if (woke) begin
                settle_ticks <= settle_ticks + int'(ms_tick);
            end
        end
    end

    // R1 R2
    gap_respected_chk: assert property (@(posedge clk) disable iff (rst)
        start_grant |-> (end_ticks >= GAP_TICKS) || irq_since);

    // R10
    grant_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_grant |=> !start_grant);

    // R6
    cs_grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_grant && wake_cs));

    // R6
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_cs) |-> (cs_ticks == CS_HOLD_TICKS));

    // R6
    settle_len_chk: assert property (@(posedge clk) disable iff (rst)
        (start_grant && woke) |-> (settle_ticks == SETTLE_TICKS));
endmodule

bind pace_wake_ctrl pace_wake_ctrl_chk #(
    .GAP_TICKS(GAP_TICKS), .CS_HOLD_TICKS(CS_HOLD_TICKS), .SETTLE_TICKS(SETTLE_TICKS)
) u_chk (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .xfer_done(xfer_done),
    .ready_irq(ready_irq), .start_grant(start_grant), .wake_cs(wake_cs)
);

// File: tb/tb_pace_wake_ctrl.sv
module tb_pace_wake_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0, xfer_done = 1'b0, start_req = 1'b0, ready_irq = 1'b0;
    logic start_grant, wake_cs;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;  // 125 MHz

    pace_wake_ctrl dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .xfer_done(xfer_done),
        .start_req(start_req), .ready_irq(ready_irq),
        .start_grant(start_grant), .wake_cs(wake_cs)
    );

    // Millisecond tick: one cycle in every four, changed away from the edge.
    initial forever begin
        @(posedge clk);
        #2;
        cyc++;
        ms_tick = (cyc % 4 == 0);
    end

    // Behavioural reference: phases 0 idle, 1 gap, 2 cs pulse, 3 settle, 4 grant.
    int m_ph, m_end, m_grt, m_att, m_tc;
    bit m_pend, m_seen, m_open, m_irqm;

    always @(posedge clk) begin
        int  lim;
        bit  met, asl, was_g;
        if (rst) begin
            m_ph = 0; m_end = 1 << 30; m_grt = 1 << 30; m_att = 0; m_tc = 0;
            m_pend = 0; m_seen = 0; m_open = 1; m_irqm = 0;
        end else begin
            lim   = m_irqm ? 750 : 3;
            met   = (m_end >= lim) || ready_irq || m_pend;
            asl   = (m_grt >= 1000);
            was_g = (m_ph == 4);
            case (m_ph)
                0: if (start_req) m_ph = 1;
                1: if (met) begin
                       if (m_open) begin
                           if (m_seen) begin m_irqm = 1; m_open = 0; end
                           else begin m_att++; if (m_att == 3) m_open = 0; end
                       end
                       m_ph = asl ? 2 : 4;
                       m_tc = 0;
                   end
                2: begin m_tc += int'(ms_tick); if (m_tc >= 2) begin m_ph = 3; m_tc = 0; end end
                3: begin m_tc += int'(ms_tick); if (m_tc >= 2) begin m_ph = 4; m_tc = 0; end end
                default: m_ph = 0;
            endcase
            m_end  = xfer_done ? 0 : m_end + int'(ms_tick);
            m_grt  = was_g ? 0 : m_grt + int'(ms_tick);
            m_pend = ready_irq ? 1'b1 : (was_g ? 1'b0 : m_pend);
            m_seen = m_seen | ready_irq;
        end
    end

    // Compare on every clock, away from the edge.
    always @(negedge clk) begin
        string tag;
        if (!rst) begin
            tag = (m_ph == 2 || m_ph == 3) ? "R6" : ((m_ph == 4) ? "R1" : "R10");
            n_chk++;
            if (start_grant !== (m_ph == 4) || wake_cs !== (m_ph == 2)) begin
                n_fail++;
                $display("FAIL %s cycle %0d grant/cs actual %0d/%0d expected %0d/%0d",
                         tag, cyc, start_grant, wake_cs, (m_ph == 4), (m_ph == 2));
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic end_pulse();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic idle_ms(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    // Issue one request at the current negedge and follow it to the grant.
    task automatic req(input int irq_at, input bit extra,
                       output int tw, output int tcs, output int tst,
                       output int gi, output int gw, output bit cs_seen);
        int i = 0;
        bit fin = 0;
        tw = 0; tcs = 0; tst = 0; gi = -1; cs_seen = 0;
        while (!fin && i < 20000) begin
            if (start_grant) begin
                gi  = i;
                fin = 1;
            end else begin
                if (wake_cs) begin cs_seen = 1; tcs += int'(ms_tick); end
                else if (cs_seen) tst += int'(ms_tick);
                else tw += int'(ms_tick);
                start_req = (i == 0) || (extra && i == 3);
                ready_irq = (i == irq_at);
                @(negedge clk);
                i++;
            end
        end
        start_req = 1'b0;
        ready_irq = 1'b0;
        @(negedge clk);
        gw = start_grant;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int tw, tcs, tst, gi, gw, extra_g;
        bit cs;
        repeat (4) @(negedge clk);
        chk(start_grant == 0 && wake_cs == 0, "R11", "outputs in reset", start_grant + wake_cs, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(start_grant == 0 && wake_cs == 0, "R11", "outputs after reset", start_grant + wake_cs, 0);

        // First request after reset: wake sequence, no gap wait.
        req(-1, 0, tw, tcs, tst, gi, gw, cs);
        chk(cs, "R5", "wake before first grant", cs, 1);
        chk(tcs == 2, "R6", "ticks with wake_cs high", tcs, 2);
        chk(tst == 2, "R6", "settle ticks", tst, 2);
        chk(gw == 0, "R10", "grant width one cycle", gw, 0);

        // Fixed gap, extra request while busy.
        end_pulse();
        req(-1, 1, tw, tcs, tst, gi, gw, cs);
        chk(tw == 3, "R1", "ticks from end to grant", tw, 3);
        chk(!cs, "R7", "no wake shortly after a grant", cs, 0);
        extra_g = 0;
        repeat (40) begin @(negedge clk); if (start_grant) extra_g++; end
        chk(extra_g == 0, "R10", "grants from request while busy", extra_g, 0);

        // Second end replaces the first.
        end_pulse();
        repeat (8) @(negedge clk);
        end_pulse();
        req(-1, 0, tw, tcs, tst, gi, gw, cs);
        chk(tw == 3, "R8", "ticks from latest end", tw, 3);

        // Three misses closed confirmation; a later interrupt still ends a wait.
        ready_irq = 1'b1;
        @(negedge clk);
        ready_irq = 1'b0;
        idle_ms(3);
        end_pulse();
        req(-1, 0, tw, tcs, tst, gi, gw, cs);
        chk(gi == 2, "R2", "stored interrupt releases wait, grant cycle", gi, 2);
        end_pulse();
        req(-1, 0, tw, tcs, tst, gi, gw, cs);
        chk(tw == 3, "R4", "fixed gap kept after late interrupt", tw, 3);
        end_pulse();
        req(2, 0, tw, tcs, tst, gi, gw, cs);
        chk(gi - 2 == 1, "R2", "cycles from interrupt to grant", gi - 2, 1);

        // Long idle then an end: gap first, then wake.
        idle_ms(1010);
        end_pulse();
        req(-1, 0, tw, tcs, tst, gi, gw, cs);
        chk(tw == 3, "R10", "gap ticks before wake_cs rises", tw, 3);
        chk(cs, "R5", "wake after sleep limit", cs, 1);

        // Fresh reset: interrupt confirmed on first request.
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ready_irq = 1'b1;
        @(negedge clk);
        ready_irq = 1'b0;
        req(-1, 0, tw, tcs, tst, gi, gw, cs);
        chk(cs, "R5", "wake with no grant since reset", cs, 1);
        end_pulse();
        req(-1, 0, tw, tcs, tst, gi, gw, cs);
        chk(tw == 750, "R3", "interrupt-mode gap ticks", tw, 750);
        chk(!cs, "R7", "no wake within deadline", cs, 0);

        idle_ms(400);
        end_pulse();
        req(0, 0, tw, tcs, tst, gi, gw, cs);
        chk(!cs, "R7", "deadline re-armed by grant without wake", cs, 0);

        idle_ms(1010);
        end_pulse();
        req(0, 0, tw, tcs, tst, gi, gw, cs);
        chk(cs, "R5", "wake after 1010 idle ticks", cs, 1);

        end_pulse();
        idle_ms(2200);
        req(-1, 0, tw, tcs, tst, gi, gw, cs);
        chk(tw <= 1, "R9", "gap met after very long idle", tw, 0);
        chk(cs, "R9", "wake after very long idle", cs, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule